// File: doc/BRIEF.md
# Enable-Driven Standby Sequencer

This block turns one active-high enable input and six phase command inputs into the power state of a three-phase gate driver. When enable goes low, the driver-stage enable drops in the same cycle. While enable stays low, a single low-time counter runs. It first reaches a short threshold, where it fires a one-cycle pulse that clears latched short-circuit events. Later it reaches a much longer threshold, where the block enters standby.

At standby entry the six phase commands are sampled once. If any of them is high, the auxiliary switching regulator stays on (mode 1). If all of them are low, the regulator is switched off (mode 0). The chosen mode then holds until enable returns.

When enable is high at a clock edge, the low-time count restarts, standby is left and the regulator is switched back on. The driver stage is released only after a start delay counted from that point. Reset is treated the same way as a fresh enable. All delays are parameters counted in clock cycles.

Top module: `standby_seq`

## Requirements
- R1: `drv_on` is 0 in any cycle where `en_in` is 0, with no clock edge needed (combinational gating).
- R2: After `CLR_CYCLES` consecutive clock edges with `en_in` low, `short_clr` is 1 for exactly one cycle. A low interval shorter than that produces no pulse, and an interval of any length produces at most one pulse.
- R3: After `STBY_CYCLES` consecutive clock edges with `en_in` low, `stby` becomes 1. At that same edge `reg_on` takes the OR of the six `phase_cmd` bits: 1 means mode 1 (regulator kept on) and 0 means mode 0 (regulator off).
- R4: While `stby` is 1, `reg_on` holds its sampled value, whatever `phase_cmd` does.
- R5: A clock edge with `en_in` high restarts the low-time count, clears `stby` and sets `reg_on` to 1. If enable returns on the edge where standby would have started, standby is not entered.
- R6: `drv_on` becomes 1 after `START_CYCLES` consecutive clock edges with `en_in` high, counted from reset release or from enable returning high.
- R7: During reset, `drv_on`, `short_clr` and `stby` are 0 and `reg_on` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_in | input | 1 | Active-high enable |
| phase_cmd | input | 6 | High and low side commands of the three phases |
| drv_on | output | 1 | Driver-stage enable |
| short_clr | output | 1 | One-cycle clear of latched short events |
| stby | output | 1 | Standby active |
| reg_on | output | 1 | Auxiliary switching regulator enable |

## Verification
Two functions can fall on the same edge: the return of enable, and the standby entry that the low-time count reaches on that edge. The bench provokes this by raising enable one cycle before the entry edge. The return must win: the scoreboard must then see no standby event, only the later release of the driver stage. The bench also raises a phase command on the exact entry edge, and drops it and raises others after entry, to show that only the entry-edge sample picks the mode.

// File: rtl/standby_seq.sv
module standby_seq #(
  parameter int CLR_CYCLES   = 500_000,
  parameter int STBY_CYCLES  = 42_500_000,
  parameter int START_CYCLES = 100_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_in,
  input  logic [5:0] phase_cmd,
  output logic       drv_on,
  output logic       short_clr,
  output logic       stby,
  output logic       reg_on
);
  localparam int LW = $clog2(STBY_CYCLES + 1);
  localparam int SW = $clog2(START_CYCLES + 1);
  localparam logic [LW-1:0] LO_CLR  = LW'(CLR_CYCLES - 1);
  localparam logic [LW-1:0] LO_STBY = LW'(STBY_CYCLES - 1);
  localparam logic [LW-1:0] LO_MAX  = LW'(STBY_CYCLES);
  localparam logic [SW-1:0] ST_MAX  = SW'(START_CYCLES);

  logic [LW-1:0] lo_cnt;
  logic [SW-1:0] st_cnt;
  logic          ready;

  assign ready  = (st_cnt == ST_MAX);
  assign drv_on = en_in & ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt    <= '0;
      st_cnt    <= '0;
      short_clr <= 1'b0;
      stby      <= 1'b0;
      reg_on    <= 1'b1;
    end else if (en_in) begin
      lo_cnt    <= '0;
      short_clr <= 1'b0;
      stby      <= 1'b0;
      reg_on    <= 1'b1;
      if (!ready) st_cnt <= st_cnt + 1'b1;
    end else begin
      st_cnt    <= '0;
      short_clr <= (lo_cnt == LO_CLR);
      if (lo_cnt != LO_MAX) lo_cnt <= lo_cnt + 1'b1;
      if (lo_cnt == LO_STBY) begin
        stby   <= 1'b1;
        reg_on <= |phase_cmd;
      end
    end
  end

  p_drv_not_in_stby_r1: assert property (@(posedge clk) disable iff (!rst_n)
    drv_on |-> !stby);
  p_clr_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    short_clr |=> !short_clr);
  p_clr_after_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(short_clr) |-> $past(!en_in));
  p_stby_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stby) |-> $past(lo_cnt) == LO_STBY);
  p_mode_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stby && $past(stby)) |-> $stable(reg_on));
  p_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en_in |=> (!stby && reg_on && lo_cnt == '0));
  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_on) |-> $past(en_in));
endmodule

// File: tb/sim_standby_seq.sv
module sim_standby_seq;
  localparam int CLR = 20, STB = 60, STR = 10;
  localparam int K_CLR = 0, K_SB0 = 1, K_SB1 = 2, K_DRV = 3;

  logic clk = 0, rst_n = 0, en_in = 1;
  logic [5:0] phase_cmd = '0;
  logic drv_on, short_clr, stby, reg_on;
  int cyc = 0, total = 0, bad = 0;
  int exp_q[$];
  bit done = 0;

  standby_seq #(.CLR_CYCLES(CLR), .STBY_CYCLES(STB), .START_CYCLES(STR)) u0 (
    .clk(clk), .rst_n(rst_n), .en_in(en_in), .phase_cmd(phase_cmd),
    .drv_on(drv_on), .short_clr(short_clr), .stby(stby), .reg_on(reg_on));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic push(input int kind, input int at);
    exp_q.push_back(kind * 100000 + at);
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // monitor: each observed event must match the queue head
  logic p_stby = 0, p_drv = 0;
  always begin
    @(negedge clk); #2;
    if (rst_n) begin
      int ev;
      ev = -1;
      if (short_clr) ev = K_CLR * 100000 + cyc;
      if (stby && !p_stby) ev = (reg_on ? K_SB1 : K_SB0) * 100000 + cyc;
      if (drv_on && !p_drv) ev = K_DRV * 100000 + cyc;
      if (ev >= 0) begin
        if (exp_q.size() == 0) chk("R2/R3/R6 unexpected event", ev, -1);
        else chk("R2/R3/R6 scoreboard event", ev, exp_q.pop_front());
      end
      p_stby = stby; p_drv = drv_on;
    end
  end

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    #1;
    chk("R7 drv_on in reset", drv_on, 0);
    chk("R7 short_clr in reset", short_clr, 0);
    chk("R7 stby in reset", stby, 0);
    chk("R7 reg_on in reset", reg_on, 1);
    @(negedge clk);
    rst_n = 1; push(K_DRV, cyc + STR);
    wait_to(cyc + STR + 3);
    chk("R6 released after reset", drv_on, 1);

    // R1 immediate drop, R2 short low pulse gives no clear
    @(negedge clk);
    c0 = cyc; en_in = 0; #1;
    chk("R1 drv_on drops with en_in", drv_on, 0);
    wait_to(c0 + 5);
    en_in = 1; push(K_DRV, cyc + STR);
    wait_to(cyc + STR + 3);
    chk("R2 no clear on short low", short_clr, 0);

    // R2 + R3 mode 1 with phase bit raised on the entry edge
    @(negedge clk);
    c0 = cyc; en_in = 0;
    push(K_CLR, c0 + CLR); push(K_SB1, c0 + STB);
    wait_to(c0 + STB - 1);
    phase_cmd = 6'b100000;
    wait_to(c0 + STB + 2);
    chk("R3 mode 1 regulator on", reg_on, 1);
    phase_cmd = 6'b000000;
    wait_to(c0 + STB + 6);
    chk("R4 mode 1 held", reg_on, 1);
    wait_to(c0 + STB + 40);
    en_in = 1; push(K_DRV, cyc + STR);
    wait_to(cyc + 2);
    chk("R5 stby left", stby, 0);
    wait_to(cyc + STR + 2);

    // R3 mode 0, R4 phase changes ignored
    @(negedge clk);
    c0 = cyc; en_in = 0;
    push(K_CLR, c0 + CLR); push(K_SB0, c0 + STB);
    wait_to(c0 + STB + 2);
    chk("R3 mode 0 regulator off", reg_on, 0);
    phase_cmd = 6'b010101;
    wait_to(cyc + 5);
    chk("R4 mode 0 held", reg_on, 0);
    chk("R4 still in standby", stby, 1);
    chk("R1 driver off in standby", drv_on, 0);
    phase_cmd = '0;
    en_in = 1; push(K_DRV, cyc + STR);
    wait_to(cyc + 2);
    chk("R5 regulator back on", reg_on, 1);
    wait_to(cyc + STR + 2);

    // R5 enable returns on the standby entry edge
    @(negedge clk);
    c0 = cyc; en_in = 0;
    push(K_CLR, c0 + CLR);
    wait_to(c0 + STB - 1);
    en_in = 1; push(K_DRV, cyc + STR);
    wait_to(c0 + STB + 2);
    chk("R5 no standby on coincident return", stby, 0);
    wait_to(cyc + STR + 4);
    chk("R6 driver released", drv_on, 1);
    chk("R2/R3/R6 scoreboard drained", exp_q.size(), 0);
    done = 1;
  end

  initial begin
    while (!done && cyc < 100000) @(negedge clk);
    if (!done) chk("watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule